// File: doc/BRIEF.md
# Return-Address Stack Memory

This block is the private storage for return addresses in a core that keeps its call stack apart from its data stack. Calls push an entry and returns pop one. Each entry holds a return address and a check tag that the caller supplies. The pop hands back the tag unchanged, so the caller can confirm after the return that nothing went wrong. Only calls, returns and a multi-entry discard move the stack pointer. The discard serves non-local returns. The stack grows upward from an empty pointer of zero.

A second port lets system software save and restore the stack on a task switch. It has indexed reads and writes of single entries and a load of the pointer. This port is served only in cycles when no call, return or discard is pending. When the stack is full, a push raises an overflow exception pulse. When the stack is empty, a pop raises an underflow pulse. A discard of more entries than are present also raises underflow. Trap software can then empty part of the stack or refill it.

Top module: `ret_stack`

## Requirements
- R1: After reset, `depth_o` is 0, and `ret_valid_o`, `ovf_o`, `unf_o` and `sv_rvalid_o` are all low.
- R2: A lone push (`call_i` only) on a non-full stack stores {address, tag} in slot `depth_o`. `depth_o` rises by one at the next clock edge.
- R3: A lone pop (`ret_i` only) on a non-empty stack takes one cycle. After the next edge, `ret_valid_o` is high for one cycle and shows the entry in slot `depth_o`-1, with the tag exactly as pushed. `depth_o` falls by one.
- R4: A push while `depth_o` is 1023 (full) pulses `ovf_o` for one cycle. It writes nothing and leaves `depth_o` unchanged.
- R5: A pop while `depth_o` is 0 pulses `unf_o` for one cycle. `ret_valid_o` stays low and `depth_o` stays 0.
- R6: A lone discard (`drop_i`) with `drop_cnt_i` <= `depth_o` lowers `depth_o` by `drop_cnt_i`. It raises no flag and no valid strobe. A count of 0 is a no-op.
- R7: A discard with `drop_cnt_i` > `depth_o` pulses `unf_o` and leaves `depth_o` unchanged.
- R8: When more than one of `call_i`, `ret_i` and `drop_i` is high in a cycle, no operation is performed. `depth_o` is unchanged and no strobe or flag follows.
- R9: `sv_ready_o` is high exactly when `call_i`, `ret_i` and `drop_i` are all low. A save-port request made while `sv_ready_o` is low has no effect. An accepted write with `sv_idx_i` < 1023 stores the entry. An accepted read raises `sv_rvalid_o` one cycle later with the entry. Index 1023 reads as all zeros, and a write to it is ignored.
- R10: `sv_depth_we_i` while `sv_ready_o` is high loads `sv_depth_i` into `depth_o` at the next edge. While `sv_ready_o` is low the load is ignored.
- R11: Save-port reads and writes never change `depth_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Push request |
| call_addr_i | input | AW | Return address to push |
| call_tag_i | input | TW | Check tag to push |
| ret_i | input | 1 | Pop request |
| drop_i | input | 1 | Discard request |
| drop_cnt_i | input | PW | Number of entries to discard |
| ret_valid_o | output | 1 | Popped entry valid |
| ret_addr_o | output | AW | Popped return address |
| ret_tag_o | output | TW | Popped check tag |
| ovf_o | output | 1 | Overflow exception pulse |
| unf_o | output | 1 | Underflow exception pulse |
| depth_o | output | PW | Current stack pointer (entry count) |
| sv_ready_o | output | 1 | Save port may be served this cycle |
| sv_en_i | input | 1 | Save-port entry access request |
| sv_we_i | input | 1 | Save-port access is a write |
| sv_idx_i | input | PW | Save-port entry index |
| sv_addr_i | input | AW | Save-port write address |
| sv_tag_i | input | TW | Save-port write tag |
| sv_rvalid_o | output | 1 | Save-port read data valid |
| sv_addr_o | output | AW | Save-port read address |
| sv_tag_o | output | TW | Save-port read tag |
| sv_depth_we_i | input | 1 | Load stack pointer |
| sv_depth_i | input | PW | Stack pointer value to load |

## Verification
The bench fills the whole 1023-entry stack with distinct address/tag pairs and then drains it. This exposes any slot-addressing or pointer off-by-one error, and any tag corruption. Pushes at full, pops at empty, and discards of zero, in-range and excess counts separate the exception paths from the normal paths. Command clashes, and save-port requests made during a pop or push, show whether arbitration really blocks an operation or only reorders it. An indexed sweep of every slot, a restore of a small context and a drain of that context confirm that both ports see the same storage.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [2:0] {
        RS_IDLE  = 3'd0,
        RS_PUSH  = 3'd1,
        RS_POP   = 3'd2,
        RS_DROP  = 3'd3,
        RS_CLASH = 3'd4
    } rs_op_e;

    // Classify the stack-port request lines of one cycle.
    function automatic rs_op_e rs_decode(input logic c, input logic r, input logic d);
        rs_op_e op;
        unique case ({c, r, d})
            3'b000:  op = RS_IDLE;
            3'b100:  op = RS_PUSH;
            3'b010:  op = RS_POP;
            3'b001:  op = RS_DROP;
            default: op = RS_CLASH;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/rs_ram.sv
module rs_ram #(
    parameter int unsigned DEPTH = 1023,
    parameter int unsigned PW    = 10,
    parameter int unsigned EW    = 48
) (
    input  logic          clk_i,
    input  logic          en_i,
    input  logic          we_i,
    input  logic [PW-1:0] addr_i,
    input  logic [EW-1:0] wdata_i,
    output logic [EW-1:0] rdata_o
);

    logic [EW-1:0] mem_q [DEPTH];
    logic [EW-1:0] rdata_q;

    // Single port: one read or one write per cycle, registered read.
    always_ff @(posedge clk_i) begin
        if (en_i) begin
            if (we_i) begin
                mem_q[addr_i] <= wdata_i;
            end else begin
                rdata_q <= mem_q[addr_i];
            end
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/rs_ctrl.sv
module rs_ctrl
    import rs_pkg::*;
#(
    parameter int unsigned PW = 10,
    parameter int unsigned AW = 32,
    parameter int unsigned TW = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             call_i,
    input  logic [AW-1:0]    call_addr_i,
    input  logic [TW-1:0]    call_tag_i,
    input  logic             ret_i,
    input  logic             drop_i,
    input  logic [PW-1:0]    drop_cnt_i,
    input  logic             sv_en_i,
    input  logic             sv_we_i,
    input  logic [PW-1:0]    sv_idx_i,
    input  logic [AW-1:0]    sv_addr_i,
    input  logic [TW-1:0]    sv_tag_i,
    input  logic             sv_depth_we_i,
    input  logic [PW-1:0]    sv_depth_i,
    output logic [PW-1:0]    depth_o,
    output logic             ret_vld_o,
    output logic             sv_vld_o,
    output logic             oob_o,
    output logic             ovf_o,
    output logic             unf_o,
    output logic             sv_ready_o,
    output logic             ram_en_o,
    output logic             ram_we_o,
    output logic [PW-1:0]    ram_addr_o,
    output logic [AW+TW-1:0] ram_wdata_o
);

    localparam int unsigned DEPTH = (1 << PW) - 1;
    localparam logic [PW-1:0] FULL = PW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] depth;
        logic          ret_vld;
        logic          sv_vld;
        logic          oob;
        logic          ovf;
        logic          unf;
    } st_t;

    st_t    s_d, s_q;
    rs_op_e op;

    always_comb begin
        op           = rs_decode(call_i, ret_i, drop_i);
        s_d          = s_q;
        s_d.ret_vld  = 1'b0;
        s_d.sv_vld   = 1'b0;
        s_d.oob      = 1'b0;
        s_d.ovf      = 1'b0;
        s_d.unf      = 1'b0;
        ram_en_o     = 1'b0;
        ram_we_o     = 1'b0;
        ram_addr_o   = '0;
        ram_wdata_o  = {call_addr_i, call_tag_i};
        sv_ready_o   = (op == RS_IDLE);

        unique case (op)
            RS_PUSH: begin
                if (s_q.depth == FULL) begin
                    s_d.ovf = 1'b1;
                end else begin
                    ram_en_o   = 1'b1;
                    ram_we_o   = 1'b1;
                    ram_addr_o = s_q.depth;
                    s_d.depth  = s_q.depth + PW'(1);
                end
            end
            RS_POP: begin
                if (s_q.depth == '0) begin
                    s_d.unf = 1'b1;
                end else begin
                    ram_en_o    = 1'b1;
                    ram_addr_o  = s_q.depth - PW'(1);
                    s_d.depth   = s_q.depth - PW'(1);
                    s_d.ret_vld = 1'b1;
                end
            end
            RS_DROP: begin
                if (drop_cnt_i > s_q.depth) begin
                    s_d.unf = 1'b1;
                end else begin
                    s_d.depth = s_q.depth - drop_cnt_i;
                end
            end
            RS_IDLE: begin
                if (sv_en_i) begin
                    if (sv_idx_i != FULL) begin
                        ram_en_o    = 1'b1;
                        ram_we_o    = sv_we_i;
                        ram_addr_o  = sv_idx_i;
                        ram_wdata_o = {sv_addr_i, sv_tag_i};
                    end else if (!sv_we_i) begin
                        s_d.oob = 1'b1;
                    end
                    s_d.sv_vld = !sv_we_i;
                end
                if (sv_depth_we_i) begin
                    s_d.depth = sv_depth_i;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign depth_o   = s_q.depth;
    assign ret_vld_o = s_q.ret_vld;
    assign sv_vld_o  = s_q.sv_vld;
    assign oob_o     = s_q.oob;
    assign ovf_o     = s_q.ovf;
    assign unf_o     = s_q.unf;

endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
    parameter int unsigned PW = 10,
    parameter int unsigned AW = 32,
    parameter int unsigned TW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          call_i,
    input  logic [AW-1:0] call_addr_i,
    input  logic [TW-1:0] call_tag_i,
    input  logic          ret_i,
    input  logic          drop_i,
    input  logic [PW-1:0] drop_cnt_i,
    output logic          ret_valid_o,
    output logic [AW-1:0] ret_addr_o,
    output logic [TW-1:0] ret_tag_o,
    output logic          ovf_o,
    output logic          unf_o,
    output logic [PW-1:0] depth_o,
    output logic          sv_ready_o,
    input  logic          sv_en_i,
    input  logic          sv_we_i,
    input  logic [PW-1:0] sv_idx_i,
    input  logic [AW-1:0] sv_addr_i,
    input  logic [TW-1:0] sv_tag_i,
    output logic          sv_rvalid_o,
    output logic [AW-1:0] sv_addr_o,
    output logic [TW-1:0] sv_tag_o,
    input  logic          sv_depth_we_i,
    input  logic [PW-1:0] sv_depth_i
);

    localparam int unsigned DEPTH = (1 << PW) - 1;
    localparam int unsigned EW    = AW + TW;

    logic          ram_en, ram_we, oob;
    logic [PW-1:0] ram_addr;
    logic [EW-1:0] ram_wdata, ram_rdata;

    rs_ctrl #(.PW(PW), .AW(AW), .TW(TW)) i_ctrl (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .call_i        (call_i),
        .call_addr_i   (call_addr_i),
        .call_tag_i    (call_tag_i),
        .ret_i         (ret_i),
        .drop_i        (drop_i),
        .drop_cnt_i    (drop_cnt_i),
        .sv_en_i       (sv_en_i),
        .sv_we_i       (sv_we_i),
        .sv_idx_i      (sv_idx_i),
        .sv_addr_i     (sv_addr_i),
        .sv_tag_i      (sv_tag_i),
        .sv_depth_we_i (sv_depth_we_i),
        .sv_depth_i    (sv_depth_i),
        .depth_o       (depth_o),
        .ret_vld_o     (ret_valid_o),
        .sv_vld_o      (sv_rvalid_o),
        .oob_o         (oob),
        .ovf_o         (ovf_o),
        .unf_o         (unf_o),
        .sv_ready_o    (sv_ready_o),
        .ram_en_o      (ram_en),
        .ram_we_o      (ram_we),
        .ram_addr_o    (ram_addr),
        .ram_wdata_o   (ram_wdata)
    );

    rs_ram #(.DEPTH(DEPTH), .PW(PW), .EW(EW)) i_ram (
        .clk_i   (clk_i),
        .en_i    (ram_en),
        .we_i    (ram_we),
        .addr_i  (ram_addr),
        .wdata_i (ram_wdata),
        .rdata_o (ram_rdata)
    );

    assign ret_addr_o = ram_rdata[EW-1:TW];
    assign ret_tag_o  = ram_rdata[TW-1:0];
    assign sv_addr_o  = oob ? '0 : ram_rdata[EW-1:TW];
    assign sv_tag_o   = oob ? '0 : ram_rdata[TW-1:0];

endmodule

// File: rtl/rs_chk.sv
module rs_chk #(
    parameter int unsigned PW = 10
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          call_i,
    input logic          ret_i,
    input logic          drop_i,
    input logic [PW-1:0] drop_cnt_i,
    input logic [PW-1:0] depth_o,
    input logic          ret_valid_o,
    input logic          ovf_o,
    input logic          unf_o,
    input logic          sv_en_i,
    input logic          sv_we_i,
    input logic          sv_ready_o,
    input logic          sv_rvalid_o
);

    localparam logic [PW-1:0] FULL = PW'((1 << PW) - 1);

    logic lone;
    assign lone = ($countones({call_i, ret_i, drop_i}) == 1);

    // R1
    reset_state_chk: assert property (@(posedge clk_i)
        $rose(rst_ni) |-> (depth_o == '0 && !ret_valid_o && !ovf_o && !unf_o));

    // R2
    push_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lone && call_i && depth_o != FULL) |=> (depth_o == $past(depth_o) + PW'(1) && !ovf_o));

    // R3
    pop_shrink_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lone && ret_i && depth_o != '0) |=> (ret_valid_o && depth_o == $past(depth_o) - PW'(1)));

    // R4
    full_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lone && call_i && depth_o == FULL) |=> (ovf_o && $stable(depth_o)));

    // R5
    empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lone && ret_i && depth_o == '0) |=> (unf_o && !ret_valid_o && depth_o == '0));

    // R7
    drop_excess_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lone && drop_i && drop_cnt_i > depth_o) |=> (unf_o && $stable(depth_o)));

    // R8
    clash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($countones({call_i, ret_i, drop_i}) > 1) |=>
            ($stable(depth_o) && !ret_valid_o && !ovf_o && !unf_o));

    // R9
    sv_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sv_en_i && !sv_we_i && sv_ready_o) |=> sv_rvalid_o);

    // R9
    sv_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sv_ready_o) |=> !sv_rvalid_o);

endmodule

bind ret_stack rs_chk #(.PW(PW)) i_rs_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .call_i      (call_i),
    .ret_i       (ret_i),
    .drop_i      (drop_i),
    .drop_cnt_i  (drop_cnt_i),
    .depth_o     (depth_o),
    .ret_valid_o (ret_valid_o),
    .ovf_o       (ovf_o),
    .unf_o       (unf_o),
    .sv_en_i     (sv_en_i),
    .sv_we_i     (sv_we_i),
    .sv_ready_o  (sv_ready_o),
    .sv_rvalid_o (sv_rvalid_o)
);

// File: tb/test_ret_stack.sv
module test_ret_stack;

    localparam int CLK_PERIOD = 10;
    localparam int PW = 10;
    localparam int AW = 32;
    localparam int TW = 16;
    localparam int FULL = (1 << PW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          call = 1'b0, ret = 1'b0, drop = 1'b0;
    logic [AW-1:0] call_addr = '0;
    logic [TW-1:0] call_tag = '0;
    logic [PW-1:0] drop_cnt = '0;
    logic          ret_valid, ovf, unf, sv_ready, sv_rvalid;
    logic [AW-1:0] ret_addr, sv_addr_out;
    logic [TW-1:0] ret_tag, sv_tag_out;
    logic [PW-1:0] depth;
    logic          sv_en = 1'b0, sv_we = 1'b0, sv_depth_we = 1'b0;
    logic [PW-1:0] sv_idx = '0, sv_depth = '0;
    logic [AW-1:0] sv_addr = '0;
    logic [TW-1:0] sv_tag = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ret_stack #(.PW(PW), .AW(AW), .TW(TW)) i_ret_stack (
        .clk_i (clk), .rst_ni (rst_n),
        .call_i (call), .call_addr_i (call_addr), .call_tag_i (call_tag),
        .ret_i (ret), .drop_i (drop), .drop_cnt_i (drop_cnt),
        .ret_valid_o (ret_valid), .ret_addr_o (ret_addr), .ret_tag_o (ret_tag),
        .ovf_o (ovf), .unf_o (unf), .depth_o (depth), .sv_ready_o (sv_ready),
        .sv_en_i (sv_en), .sv_we_i (sv_we), .sv_idx_i (sv_idx),
        .sv_addr_i (sv_addr), .sv_tag_i (sv_tag), .sv_rvalid_o (sv_rvalid),
        .sv_addr_o (sv_addr_out), .sv_tag_o (sv_tag_out),
        .sv_depth_we_i (sv_depth_we), .sv_depth_i (sv_depth)
    );

    function automatic logic [AW-1:0] ea(input int i);
        return 32'h4000_0000 + AW'(i) * 8;
    endfunction
    function automatic logic [TW-1:0] et(input int i);
        return TW'(i * 37 + 5);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear();
        call = 0; ret = 0; drop = 0; sv_en = 0; sv_we = 0; sv_depth_we = 0;
    endtask

    task automatic do_push(input logic [AW-1:0] a, input logic [TW-1:0] t);
        call = 1; call_addr = a; call_tag = t;
        tick(); clear();
    endtask

    task automatic do_pop();
        ret = 1; tick(); clear();
    endtask

    task automatic do_drop(input int n);
        drop = 1; drop_cnt = PW'(n); tick(); clear();
    endtask

    task automatic sv_write(input int idx, input logic [AW-1:0] a, input logic [TW-1:0] t);
        sv_en = 1; sv_we = 1; sv_idx = PW'(idx); sv_addr = a; sv_tag = t;
        tick(); clear();
    endtask

    task automatic sv_read(input int idx);
        sv_en = 1; sv_we = 0; sv_idx = PW'(idx);
        tick(); clear();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        chk("R1", "depth", 64'(depth), 0);
        chk("R1", "flags", 64'({ret_valid, ovf, unf, sv_rvalid}), 0);

        // R5 pop at empty
        do_pop();
        chk("R5", "unf", 64'(unf), 1);
        chk("R5", "valid", 64'(ret_valid), 0);
        chk("R5", "depth", 64'(depth), 0);

        // R7 excess discard at empty, R6 zero discard
        do_drop(1);
        chk("R7", "unf", 64'(unf), 1);
        chk("R7", "depth", 64'(depth), 0);
        do_drop(0);
        chk("R6", "zero drop flags", 64'({unf, ovf, ret_valid}), 0);
        chk("R6", "zero drop depth", 64'(depth), 0);

        // R2 fill the whole stack
        for (int i = 0; i < FULL; i++) begin
            do_push(ea(i), et(i));
            chk("R2", "depth after push", 64'(depth), 64'(i + 1));
        end

        // R4 push at full
        do_push(32'hDEAD_BEEF, 16'hBAD0);
        chk("R4", "ovf", 64'(ovf), 1);
        chk("R4", "depth", 64'(depth), 64'(FULL));
        do_pop();
        chk("R4", "top entry untouched", 64'({ret_addr, ret_tag}), 64'({ea(FULL - 1), et(FULL - 1)}));
        chk("R3", "valid", 64'(ret_valid), 1);
        do_push(ea(FULL - 1), et(FULL - 1));

        // R8 clashing commands
        call = 1; ret = 1; call_addr = 32'h1; tick(); clear();
        chk("R8", "call+ret depth", 64'(depth), 64'(FULL));
        chk("R8", "call+ret strobes", 64'({ret_valid, ovf, unf}), 0);
        ret = 1; drop = 1; drop_cnt = 5; tick(); clear();
        chk("R8", "ret+drop depth", 64'(depth), 64'(FULL));
        chk("R8", "ret+drop strobes", 64'({ret_valid, ovf, unf}), 0);

        // R9 indexed read sweep, R11 depth unaffected
        for (int i = 0; i < FULL; i++) begin
            #1 chk("R9", "ready when idle", 64'(sv_ready), 1);
            sv_read(i);
            chk("R9", "read valid", 64'(sv_rvalid), 1);
            chk("R9", "read entry", 64'({sv_addr_out, sv_tag_out}), 64'({ea(i), et(i)}));
        end
        chk("R11", "depth after reads", 64'(depth), 64'(FULL));

        // R9 save-port write blocked by pop
        ret = 1; sv_en = 1; sv_we = 1; sv_idx = 5; sv_addr = 32'h0BAD_0BAD; sv_tag = 16'h7777;
        #1 chk("R9", "not ready while popping", 64'(sv_ready), 0);
        tick(); clear();
        chk("R3", "pop data", 64'({ret_addr, ret_tag}), 64'({ea(FULL - 1), et(FULL - 1)}));
        chk("R3", "depth", 64'(depth), 64'(FULL - 1));
        sv_read(5);
        chk("R9", "blocked write had no effect", 64'({sv_addr_out, sv_tag_out}), 64'({ea(5), et(5)}));

        // R6 in-range discard, R7 excess discard
        do_drop(3);
        chk("R6", "depth after drop 3", 64'(depth), 64'(FULL - 4));
        chk("R6", "drop strobes", 64'({ret_valid, unf}), 0);
        do_drop(FULL);
        chk("R7", "unf", 64'(unf), 1);
        chk("R7", "depth kept", 64'(depth), 64'(FULL - 4));

        // R3 drain the remainder
        for (int i = FULL - 5; i >= 0; i--) begin
            do_pop();
            chk("R3", "pop entry", 64'({ret_valid, ret_addr, ret_tag}), 64'({1'b1, ea(i), et(i)}));
            chk("R3", "depth after pop", 64'(depth), 64'(i));
        end

        // R9 out-of-range index
        sv_write(FULL, 32'h1234_5678, 16'h4321);
        sv_read(FULL);
        chk("R9", "index 1023 reads zero", 64'({sv_rvalid, sv_addr_out, sv_tag_out}), 64'({1'b1, 48'h0}));

        // R10 context restore
        for (int i = 0; i < 10; i++) sv_write(i, ea(i + 500), et(i + 500));
        chk("R11", "depth after writes", 64'(depth), 0);
        sv_depth_we = 1; sv_depth = 10; tick(); clear();
        chk("R10", "depth loaded", 64'(depth), 10);
        for (int i = 9; i >= 0; i--) begin
            do_pop();
            chk("R10", "restored entry", 64'({ret_addr, ret_tag}), 64'({ea(i + 500), et(i + 500)}));
        end

        // R10 pointer load ignored during a push
        call = 1; call_addr = 32'hABC0; call_tag = 16'h1; sv_depth_we = 1; sv_depth = 500;
        tick(); clear();
        chk("R10", "load ignored while busy", 64'(depth), 1);
        do_pop();
        chk("R2", "pushed entry", 64'({ret_addr, ret_tag}), 64'({32'hABC0, 16'h1}));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule